// File: doc/BRIEF.md
# Obstacle-Avoidance Turn Controller

This block is a small synchronous Mealy state machine that tells a robot how to steer. The robot drives straight while its path is clear. When the one-bit obstacle flag goes high, the block orders a turn, and it keeps ordering that turn until the flag drops. It remembers which way it turned last time, so the next obstacle is met with a turn the other way. Right and left turns therefore alternate across successive obstacles.

The present state sits in two flip-flops. The next-state logic and the action decode are purely combinational. Because the machine is of the Mealy kind, the action code follows the obstacle flag within the same cycle, with no register in the output path. A synchronous, active-high clear returns the machine to its home state. The two state bits also leave the block on a status port.

The four states, with their codes on `state_o`, are:
- `ST_CLEAR_LEFT` (00): path clear, last turn was left. This is the home state.
- `ST_TURN_RIGHT` (01): obstacle present, turning right.
- `ST_CLEAR_RIGHT` (11): path clear, last turn was right.
- `ST_TURN_LEFT` (10): obstacle present, turning left.

The named transitions are:
- hold-clear-left: 00 stays at 00 when the path is clear.
- start-right: 00 goes to 01 on an obstacle.
- keep-right: 01 stays at 01 while the obstacle remains.
- end-right: 01 goes to 11 when the path clears.
- hold-clear-right: 11 stays at 11 when the path is clear.
- start-left: 11 goes to 10 on an obstacle.
- keep-left: 10 stays at 10 while the obstacle remains.
- end-left: 10 goes to 00 when the path clears.

Top module: `turn_steer_fsm`

## Requirements
- R1: When `clr` is 1 at a rising clock edge, `state_o` is 00 after that edge, whatever the value of `blocked`.
- R2: In state 00, `blocked`=0 keeps state 00 with `action`=00, and `blocked`=1 moves to state 01 with `action`=01.
- R3: In state 01, `blocked`=0 moves to state 11 with `action`=00, and `blocked`=1 keeps state 01 with `action`=01.
- R4: In state 11, `blocked`=0 keeps state 11 with `action`=00, and `blocked`=1 moves to state 10 with `action`=10.
- R5: In state 10, `blocked`=0 moves to state 00 with `action`=00, and `blocked`=1 keeps state 10 with `action`=10.
- R6: `action` is a combinational function of `blocked` and the present state. A change of `blocked` inside a cycle shows on `action` before the next clock edge, and the state does not change until that edge. `action[1]` (left) equals `blocked` AND `state_o[1]`. `action[0]` (right) equals `blocked` AND NOT `state_o[1]`.
- R7: `action` never takes the code 11. The codes are 00 = straight, 01 = turn right, 10 = turn left.
- R8: Each new turn episode (`action` going from 00 to a turn code) turns the opposite way to the previous episode. The first episode after a clear is a right turn.
- R9: `state_o` always shows the present state code: 00, 01, 11 or 10, as defined in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, forces state 00 |
| blocked | input | 1 | 1 = obstacle ahead, 0 = path clear |
| action | output | 2 | Steering command: 00 straight, 01 right, 10 left |
| state_o | output | 2 | Present state code |

## Verification
The bench builds the block with the package defaults: a 2-bit state and a 2-bit action code. With these widths the state space has exactly four codes, so every state and every transition between them can be reached. The fixed vector table walks all eight transitions in turn. A long pseudo-random run of the obstacle flag is then compared, cycle by cycle, with a table-driven model. That run covers many obstacle episodes, long and short, so the alternation rule can be checked across them.

// File: rtl/turn_steer_pkg.sv
package turn_steer_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int STATE_W = 2;
    localparam int ACT_W   = 2;

    // Gray-ordered ring: each step flips exactly one state bit.
    typedef enum logic [STATE_W-1:0] {
        ST_CLEAR_LEFT  = 2'b00,
        ST_TURN_RIGHT  = 2'b01,
        ST_CLEAR_RIGHT = 2'b11,
        ST_TURN_LEFT   = 2'b10
    } steer_state_e;

    typedef enum logic [ACT_W-1:0] {
        ACT_STRAIGHT = 2'b00,
        ACT_RIGHT    = 2'b01,
        ACT_LEFT     = 2'b10
    } steer_act_e;
endpackage

// File: rtl/turn_steer_next.sv
module turn_steer_next
    import turn_steer_pkg::*;
(
    input  steer_state_e cur,
    input  logic         blocked,
    output steer_state_e nxt
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_CLEAR_LEFT:  nxt = blocked ? ST_TURN_RIGHT : ST_CLEAR_LEFT;
            ST_TURN_RIGHT:  nxt = blocked ? ST_TURN_RIGHT : ST_CLEAR_RIGHT;
            ST_CLEAR_RIGHT: nxt = blocked ? ST_TURN_LEFT  : ST_CLEAR_RIGHT;
            ST_TURN_LEFT:   nxt = blocked ? ST_TURN_LEFT  : ST_CLEAR_LEFT;
            default:        nxt = ST_CLEAR_LEFT;
        endcase
    end
endmodule

// File: rtl/turn_steer_out.sv
module turn_steer_out
    import turn_steer_pkg::*;
(
    input  steer_state_e cur,
    input  logic         blocked,
    output steer_act_e   act
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        act = ACT_STRAIGHT;
        unique case (cur)
            ST_CLEAR_LEFT,
            ST_TURN_RIGHT:  act = blocked ? ACT_RIGHT : ACT_STRAIGHT;
            ST_CLEAR_RIGHT,
            ST_TURN_LEFT:   act = blocked ? ACT_LEFT  : ACT_STRAIGHT;
            default:        act = ACT_STRAIGHT;
        endcase
    end

    // R7: the unused code must never leave the decoder
    always_comb begin
        a_r7_no_code11: assert (act !== 2'b11);
    end
endmodule

// File: rtl/turn_steer_fsm.sv
module turn_steer_fsm
    import turn_steer_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             blocked,
    output logic [ACT_W-1:0] action,
    output logic [STATE_W-1:0] state_o
);
    timeunit 1ns;
    timeprecision 1ps;

    steer_state_e state_q;
    steer_state_e state_d;
    steer_act_e   act_w;

    turn_steer_next u_next (
        .cur     (state_q),
        .blocked (blocked),
        .nxt     (state_d)
    );

    turn_steer_out u_out (
        .cur     (state_q),
        .blocked (blocked),
        .act     (act_w)
    );

    always_ff @(posedge clk) begin
        if (clr) state_q <= ST_CLEAR_LEFT;
        else     state_q <= state_d;
    end

    assign action  = act_w;
    assign state_o = state_q;

    // R1: clear lands in home state
    a_r1_clear_home: assert property (@(posedge clk)
        clr |=> state_o == 2'b00);

    // R2: transitions out of 00
    a_r2_hold_clear_left: assert property (@(posedge clk) disable iff (clr)
        (state_o == 2'b00 && !blocked) |=> state_o == 2'b00);
    a_r2_start_right: assert property (@(posedge clk) disable iff (clr)
        (state_o == 2'b00 && blocked) |=> state_o == 2'b01);

    // R3: transitions out of 01
    a_r3_end_right: assert property (@(posedge clk) disable iff (clr)
        (state_o == 2'b01 && !blocked) |=> state_o == 2'b11);
    a_r3_keep_right: assert property (@(posedge clk) disable iff (clr)
        (state_o == 2'b01 && blocked) |=> state_o == 2'b01);

    // R4: transitions out of 11
    a_r4_hold_clear_right: assert property (@(posedge clk) disable iff (clr)
        (state_o == 2'b11 && !blocked) |=> state_o == 2'b11);
    a_r4_start_left: assert property (@(posedge clk) disable iff (clr)
        (state_o == 2'b11 && blocked) |=> state_o == 2'b10);

    // R5: transitions out of 10
    a_r5_end_left: assert property (@(posedge clk) disable iff (clr)
        (state_o == 2'b10 && !blocked) |=> state_o == 2'b00);
    a_r5_keep_left: assert property (@(posedge clk) disable iff (clr)
        (state_o == 2'b10 && blocked) |=> state_o == 2'b10);

    // R6: no obstacle means no turn; an obstacle always means some turn
    a_r6_quiet_when_clear: assert property (@(posedge clk) disable iff (clr)
        !blocked |-> action == 2'b00);
    a_r6_turn_when_blocked: assert property (@(posedge clk) disable iff (clr)
        blocked |-> $countones(action) == 1);
endmodule

// File: tb/turn_steer_fsm_bench.sv
module turn_steer_fsm_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       blocked = 1'b0;
    logic [1:0] action;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    turn_steer_fsm u_turn_steer_fsm (
        .clk     (clk),
        .clr     (clr),
        .blocked (blocked),
        .action  (action),
        .state_o (state_o)
    );

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    // Each entry is {blocked, expected present state, expected action}.
    localparam logic [4:0] VEC [13] = '{
        5'b0_00_00, 5'b1_00_01, 5'b1_01_01, 5'b0_01_00,
        5'b0_11_00, 5'b1_11_10, 5'b1_10_10, 5'b0_10_00,
        5'b1_00_01, 5'b0_01_00, 5'b1_11_10, 5'b0_10_00,
        5'b0_00_00
    };

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic b);
        case (s)
            2'b00:   return b ? 2'b01 : 2'b00;
            2'b01:   return b ? 2'b01 : 2'b11;
            2'b11:   return b ? 2'b10 : 2'b11;
            default: return b ? 2'b10 : 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] ref_act(input logic [1:0] s, input logic b);
        if (!b) return 2'b00;
        return (s == 2'b00 || s == 2'b01) ? 2'b01 : 2'b10;
    endfunction

    function automatic string req_of(input logic [1:0] s);
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        logic [1:0]  ref_s;
        logic [1:0]  prev_act;
        logic [1:0]  last_turn;
        logic [15:0] lfsr;

        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset state", state_o, 2'b00);
        chk("R1 reset action", action, 2'b00);
        clr = 1'b0;

        // Vector table: every named transition
        for (int i = 0; i < 13; i++) begin
            if (i > 0) @(negedge clk);
            blocked = VEC[i][4];
            #1;
            chk({req_of(VEC[i][3:2]), " R9 state"}, state_o, VEC[i][3:2]);
            chk({req_of(VEC[i][3:2]), " action"}, action, VEC[i][1:0]);
        end

        // R6: action follows blocked inside a cycle, state unchanged
        @(negedge clk);
        blocked = 1'b1;
        #1;
        chk("R6 same-cycle turn", action, 2'b01);
        blocked = 1'b0;
        #1;
        chk("R6 same-cycle release", action, 2'b00);
        chk("R6 state unchanged", state_o, 2'b00);

        // Random run against a table-driven model
        ref_s     = 2'b00;
        prev_act  = 2'b00;
        last_turn = 2'b10;   // home state means last turn was left
        lfsr      = 16'hACE1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            blocked = lfsr[0] & (lfsr[3] | lfsr[7]);
            #1;
            chk("R9 random state", state_o, ref_s);
            chk({req_of(ref_s), " random action"}, action, ref_act(ref_s, blocked));
            checks++;
            if (action === 2'b11) begin
                errors++;
                $display("FAIL R7: got %b expected not 11", action);
            end
            if (prev_act == 2'b00 && action != 2'b00) begin
                chk("R8 alternation", action, (last_turn == 2'b01) ? 2'b10 : 2'b01);
                last_turn = action;
            end
            prev_act = action;
            ref_s = ref_next(ref_s, blocked);
        end

        // R1: clear overrides an obstacle, from a turning state
        @(negedge clk);
        clr = 1'b0;
        blocked = 1'b1;
        repeat (3) @(negedge clk);   // reaches a turning state (01 or 10)
        clr = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 clear with obstacle", state_o, 2'b00);
        @(negedge clk);
        clr = 1'b0;
        #1;
        chk("R1 after clear first turn right R8", action, 2'b01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule